// File: doc/BRIEF.md
# Short/Long Hardware Reset Sequencer

This block turns an active-low external reset pin into an orderly internal reset for a microcontroller. The pin is first brought into the clock domain by a two-stage synchronizer. A counting glitch filter then removes low pulses that are too short to count as a reset. Each clock cycle of the block counts as one clock phase. When the filter reports a low level, the block asserts its internal reset and runs a fixed count of `SEQ_LEN` phases. At the last phase of the count it samples the filtered pin. If the pin is already high, the event is a short reset and the internal reset ends at once. If the pin is still low, the event is a long reset and the internal reset stays on until the filtered pin goes high. After the internal reset ends, the external reset output stays low for `EXT_HOLD` more phases.

Software can arm a bidirectional mode with a one-cycle set pulse. The armed bit is consumed and cleared when a sequence starts. While that sequence counts, the block pulls the reset pin low. It lets go of the pin early enough that its own pull has passed the filter before the sample point. A separate request input comes from a power-down comparator. If that request is high while the synchronized pin is low, it overrides the sequence in any state and puts the block into asynchronous reset. A status code latched at each decision reports the kind of the last reset.

The controller is built around five named states. `ST_IDLE` waits for the filtered pin to go low. `ST_COUNT` runs the fixed count. `ST_LONG_WAIT` holds a long reset. `ST_EXT_HOLD` extends the external output. `ST_ASYNC` is the asynchronous reset. The transitions are:

- `ST_IDLE -> ST_COUNT` when the filtered pin is low.
- `ST_COUNT -> ST_EXT_HOLD` at the sample point when the filtered pin is high (short reset).
- `ST_COUNT -> ST_LONG_WAIT` at the sample point when the filtered pin is low (long reset).
- `ST_LONG_WAIT -> ST_EXT_HOLD` when the filtered pin goes high.
- `ST_ASYNC -> ST_EXT_HOLD` when the filtered pin is high and the request is low.
- `ST_EXT_HOLD -> ST_IDLE` after `EXT_HOLD` phases.
- Any state other than `ST_ASYNC` goes to `ST_ASYNC` on the pre-emption condition described above.

Top module: `hw_reset_seq`

## Requirements
- R1: While `por_n` is low, and in the cycle after it goes low, the outputs read: `int_rst`=0, `ext_rst_n`=1, `pin_pull`=0, `async_rst`=0, `rst_kind`=0, `bd_en`=0.
- R2: A low level on `rst_pin_n` starts a reset only if it is sampled on at least `FILT_LEN` consecutive rising clock edges. A shorter low pulse leaves every output unchanged.
- R3: `int_rst` rises right after the (`FILT_LEN`+3)th rising edge, counting from the first edge that samples the pin low.
- R4: In a short reset, `int_rst` stays high for exactly `SEQ_LEN` cycles.
- R5: At the last count cycle the block samples the filtered pin. If the pin is low, the reset is long, and `int_rst` stays high until the filtered pin goes high. For a pin held low on L ≥ `SEQ_LEN`+1 edges, `int_rst` is high for exactly L cycles. For L ≤ `SEQ_LEN`, the reset is short.
- R6: `ext_rst_n` is low whenever `int_rst` is high. It stays low for exactly `EXT_HOLD` cycles after `int_rst` falls.
- R7: A one-cycle `bd_set` pulse in `ST_IDLE` sets `bd_en`. Entering `ST_COUNT` clears `bd_en`. In that sequence, `pin_pull` is high for the first `SEQ_LEN`-`FILT_LEN`-4 count cycles. The block's own pull never makes the reset long.
- R8: If `async_req` is high while the synchronized pin is low, `async_rst` and `int_rst` are high after the next edge, whatever the state. The block leaves this state only once the filtered pin is high and `async_req` is low. `ext_rst_n` then follows R6.
- R9: `async_req` has no effect while the pin is high in `ST_IDLE`.
- R10: Pin activity during `ST_COUNT` neither restarts nor lengthens the count. Only the level at the sample point matters.
- R11: After `ST_EXT_HOLD` ends, a new qualifying low pulse starts a new sequence with the same timing.
- R12: `rst_kind` encodes 0 = none since power-on, 1 = short, 2 = long, 3 = asynchronous. It is latched at each decision and holds until the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| por_n | input | 1 | Power-on reset of the block, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin level, active low |
| async_req | input | 1 | Power-down comparator request for asynchronous reset |
| bd_set | input | 1 | One-cycle pulse that arms the bidirectional pin mode |
| int_rst | output | 1 | Internal reset, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| pin_pull | output | 1 | Open-drain enable that pulls the reset pin low |
| async_rst | output | 1 | Asynchronous reset state active |
| rst_kind | output | 2 | Kind of the last reset (see R12) |
| bd_en | output | 1 | Bidirectional mode armed |

## Verification
The bench builds the block with `FILT_LEN`=8, `SEQ_LEN`=64 and `EXT_HOLD`=8. With these values a whole long reset fits in a few hundred cycles, so the run can cover many cases. Both filter edges can be hit exactly, with pulses of 7 and 8 samples. Both classification edges can be hit exactly, with holds of 64 and 65 samples. The bidirectional release window is then 52 cycles, short enough to count cycle by cycle. The same values let the asynchronous request be applied during the filter, in the middle of the count, and during a long hold, all within one short run.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_COUNT     = 3'd1,
        ST_LONG_WAIT = 3'd2,
        ST_EXT_HOLD  = 3'd3,
        ST_ASYNC     = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_LONG  = 2'd2,
        KIND_ASYNC = 2'd3
    } rst_kind_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_n,
    output logic q_n
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[i] <= 1'b1;
                    else        chain[i] <= d_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];

endmodule

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
    parameter int FILT_LEN = 25
) (
    input  logic clk,
    input  logic por_n,
    input  logic in_n,
    output logic out_n
);

    localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [FW-1:0] RUN_LAST = FW'(FILT_LEN - 1);

    logic [FW-1:0] run_cnt;

    // The output flips only after the input has disagreed with it
    // on FILT_LEN consecutive samples.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            out_n   <= 1'b1;
            run_cnt <= '0;
        end else if (in_n == out_n) begin
            run_cnt <= '0;
        end else if (run_cnt == RUN_LAST) begin
            out_n   <= in_n;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + FW'(1);
        end
    end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int FILT_LEN = 25,
    parameter int SEQ_LEN  = 1024,
    parameter int EXT_HOLD = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_sync_n,
    input  logic       pin_filt_n,
    input  logic       async_req,
    input  logic       bd_set,
    output logic       int_rst,
    output logic       ext_rst_n,
    output logic       pin_pull,
    output logic       async_rst,
    output rst_kind_e  kind,
    output logic       bd_en
);

    localparam int CMAX = (SEQ_LEN > EXT_HOLD) ? SEQ_LEN : EXT_HOLD;
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
    localparam logic [CW-1:0] SEQ_LAST  = CW'(SEQ_LEN - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(EXT_HOLD - 1);
    // Own pull ends early enough to clear synchronizer and filter
    // before the sample point.
    localparam logic [CW-1:0] DRIVE_END = CW'(SEQ_LEN - FILT_LEN - 4);

    seq_state_e    st, nxt;
    logic [CW-1:0] cnt;
    logic          bd_active;
    logic          async_go;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt      = st;
        async_go = async_req && !pin_sync_n && (st != ST_ASYNC);
        unique case (st)
            ST_IDLE:      if (!pin_filt_n) nxt = ST_COUNT;
            ST_COUNT:     if (cnt == SEQ_LAST)
                              nxt = pin_filt_n ? ST_EXT_HOLD : ST_LONG_WAIT;
            ST_LONG_WAIT: if (pin_filt_n) nxt = ST_EXT_HOLD;
            ST_EXT_HOLD:  if (cnt == HOLD_LAST) nxt = ST_IDLE;
            ST_ASYNC:     if (pin_filt_n && !async_req) nxt = ST_EXT_HOLD;
            default:      nxt = ST_IDLE;
        endcase
        if (async_go) nxt = ST_ASYNC;
    end

    // Phase counter, kind latch and bidirectional bit
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt       <= '0;
            kind      <= KIND_NONE;
            bd_en     <= 1'b0;
            bd_active <= 1'b0;
        end else begin
            if (nxt != st)
                cnt <= '0;
            else if (st == ST_COUNT || st == ST_EXT_HOLD)
                cnt <= cnt + CW'(1);

            if (nxt == ST_ASYNC && st != ST_ASYNC)
                kind <= KIND_ASYNC;
            else if (st == ST_COUNT && nxt == ST_EXT_HOLD)
                kind <= KIND_SHORT;
            else if (st == ST_COUNT && nxt == ST_LONG_WAIT)
                kind <= KIND_LONG;

            if (st == ST_IDLE && nxt == ST_COUNT) begin
                bd_active <= bd_en;
                bd_en     <= 1'b0;
            end else if (nxt == ST_ASYNC) begin
                bd_active <= 1'b0;
                bd_en     <= 1'b0;
            end else begin
                if (st == ST_COUNT && nxt != ST_COUNT)
                    bd_active <= 1'b0;
                if (bd_set && st == ST_IDLE)
                    bd_en <= 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        int_rst   = 1'b0;
        ext_rst_n = 1'b0;
        pin_pull  = 1'b0;
        async_rst = 1'b0;
        unique case (st)
            ST_IDLE:      ext_rst_n = 1'b1;
            ST_COUNT: begin
                int_rst  = 1'b1;
                pin_pull = bd_active && (cnt < DRIVE_END);
            end
            ST_LONG_WAIT: int_rst = 1'b1;
            ST_EXT_HOLD:  int_rst = 1'b0;
            ST_ASYNC: begin
                int_rst   = 1'b1;
                async_rst = 1'b1;
            end
            default:      ext_rst_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/hw_reset_seq.sv
module hw_reset_seq #(
    parameter int FILT_LEN = 25,
    parameter int SEQ_LEN  = 1024,
    parameter int EXT_HOLD = 8,
    parameter int SYNC_STG = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin_n,
    input  logic       async_req,
    input  logic       bd_set,
    output logic       int_rst,
    output logic       ext_rst_n,
    output logic       pin_pull,
    output logic       async_rst,
    output logic [1:0] rst_kind,
    output logic       bd_en
);

    logic                 pin_sync_n;
    logic                 pin_filt_n;
    rstseq_pkg::rst_kind_e kind;

    rstseq_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_n   (rst_pin_n),
        .q_n   (pin_sync_n)
    );

    rstseq_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .por_n (por_n),
        .in_n  (pin_sync_n),
        .out_n (pin_filt_n)
    );

    rstseq_fsm #(
        .FILT_LEN (FILT_LEN),
        .SEQ_LEN  (SEQ_LEN),
        .EXT_HOLD (EXT_HOLD)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .pin_sync_n (pin_sync_n),
        .pin_filt_n (pin_filt_n),
        .async_req  (async_req),
        .bd_set     (bd_set),
        .int_rst    (int_rst),
        .ext_rst_n  (ext_rst_n),
        .pin_pull   (pin_pull),
        .async_rst  (async_rst),
        .kind       (kind),
        .bd_en      (bd_en)
    );

    assign rst_kind = kind;

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
    input logic       clk,
    input logic       por_n,
    input logic       pin_sync_n,
    input logic       pin_filt_n,
    input logic       async_req,
    input logic       int_rst,
    input logic       ext_rst_n,
    input logic       pin_pull,
    input logic       async_rst,
    input logic [1:0] rst_kind
);

    p_ext_covers_int_r6: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |-> !ext_rst_n);

    p_ext_after_int_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(int_rst) |-> !ext_rst_n);

    p_async_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
        (async_req && !pin_sync_n) |=> (async_rst && int_rst));

    p_start_filtered_r2: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(int_rst) && !async_rst) |-> $past(!pin_filt_n));

    p_pull_in_seq_r7: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull |-> (int_rst && !async_rst));

    p_kind_async_r12: assert property (@(posedge clk) disable iff (!por_n)
        async_rst |-> (rst_kind == 2'd3));

endmodule

bind hw_reset_seq rstseq_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .pin_sync_n (pin_sync_n),
    .pin_filt_n (pin_filt_n),
    .async_req  (async_req),
    .int_rst    (int_rst),
    .ext_rst_n  (ext_rst_n),
    .pin_pull   (pin_pull),
    .async_rst  (async_rst),
    .rst_kind   (rst_kind)
);

// File: tb/tb_hw_reset_seq.sv
module tb_hw_reset_seq;

    localparam int F = 8;
    localparam int S = 64;
    localparam int H = 8;

    // Vector table: low length in edges, expected int_rst cycles, expected kind
    localparam int NV = 7;
    localparam int V_LEN  [NV] = '{1, F-1, F, 20, S, S+1, 100};
    localparam int V_INT  [NV] = '{0, 0,   S, S,  S, S+1, 100};
    localparam int V_KIND [NV] = '{0, 0,   1, 1,  1, 2,   2};

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       drv_n = 1'b1;
    logic       async_req = 1'b0;
    logic       bd_set = 1'b0;
    logic       pin_n;
    logic       int_rst, ext_rst_n, pin_pull, async_rst, bd_en;
    logic [1:0] rst_kind;

    int n_chk  = 0;
    int n_fail = 0;

    assign pin_n = drv_n & ~pin_pull;

    always #10 clk = ~clk;

    hw_reset_seq #(.FILT_LEN(F), .SEQ_LEN(S), .EXT_HOLD(H)) dut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (pin_n),
        .async_req (async_req),
        .bd_set    (bd_set),
        .int_rst   (int_rst),
        .ext_rst_n (ext_rst_n),
        .pin_pull  (pin_pull),
        .async_rst (async_rst),
        .rst_kind  (rst_kind),
        .bd_en     (bd_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Low pulse of len edges, then watch int_rst / ext_rst_n / pin_pull.
    task automatic pulse_window(input int len, output int hi, output int ext_lo,
                                output int pulls);
        hi = 0; ext_lo = 0; pulls = 0;
        for (int c = 0; c < len + S + F + H + 30; c++) begin
            @(negedge clk);
            drv_n = (c < len) ? 1'b0 : 1'b1;
            if (int_rst)    hi++;
            if (!ext_rst_n) ext_lo++;
            if (pin_pull)   pulls++;
        end
    endtask

    // After int_rst falls, count cycles with ext_rst_n still low.
    task automatic ext_tail(output int n);
        int guard = 0;
        n = 0;
        while (int_rst && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        while (!ext_rst_n && guard < 1000) begin
            n++;
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic async_at(input int delay, input string where);
        int tail;
        @(negedge clk);
        drv_n = 1'b0;
        repeat (delay) @(negedge clk);
        async_req = 1'b1;
        @(negedge clk);
        check({"R8 async_rst ", where}, async_rst, 1);
        check({"R8 int_rst ", where}, int_rst, 1);
        check({"R12 kind async ", where}, rst_kind, 3);
        repeat (3) @(negedge clk);
        check({"R8 held while requested ", where}, async_rst, 1);
        async_req = 1'b0;
        drv_n = 1'b1;
        ext_tail(tail);
        check({"R8 ext tail after async ", where}, tail, H);
        check({"R8 async cleared ", where}, async_rst, 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi, lo, pulls;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 int_rst", int_rst, 0);
        check("R1 ext_rst_n", ext_rst_n, 1);
        check("R1 pin_pull", pin_pull, 0);
        check("R1 async_rst", async_rst, 0);
        check("R1 rst_kind", rst_kind, 0);
        check("R1 bd_en", bd_en, 0);
        por_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: R2 filter, R4 short, R5 long, R6 tail, R11 re-entry, R12
        for (int v = 0; v < NV; v++) begin
            pulse_window(V_LEN[v], hi, lo, pulls);
            check($sformatf("R2/R4/R5/R11 int cycles len=%0d", V_LEN[v]), hi, V_INT[v]);
            check($sformatf("R6 ext cycles len=%0d", V_LEN[v]), lo,
                  (V_INT[v] == 0) ? 0 : V_INT[v] + H);
            check($sformatf("R12 kind len=%0d", V_LEN[v]), rst_kind, V_KIND[v]);
        end

        // R7: bidirectional mode
        @(negedge clk);
        bd_set = 1'b1;
        @(negedge clk);
        bd_set = 1'b0;
        check("R7 bd_en armed", bd_en, 1);
        pulse_window(F + 2, hi, lo, pulls);
        check("R7 pull cycles", pulls, S - F - 4);
        check("R7 own pull stays short", rst_kind, 1);
        check("R7 int cycles", hi, S);
        check("R7 bd_en cleared", bd_en, 0);

        // R3: exact assertion latency
        @(negedge clk);
        drv_n = 1'b0;
        repeat (F + 2) @(negedge clk);
        check("R3 not yet asserted", int_rst, 0);
        @(negedge clk);
        check("R3 asserted", int_rst, 1);
        drv_n = 1'b1;
        hi = 1;
        for (int c = 0; c < S + 20; c++) begin
            @(negedge clk);
            if (int_rst) hi++;
        end
        check("R3/R4 length after latency test", hi, S);
        repeat (H + 4) @(negedge clk);

        // R10: pin activity during count is ignored
        @(negedge clk);
        drv_n = 1'b0;
        hi = 0;
        for (int c = 0; c < F + S + H + 30; c++) begin
            if (c == F + 2) drv_n = 1'b1;
            if (c == F + 12) drv_n = 1'b0;
            if (c == F + 15) drv_n = 1'b1;
            if (c == F + 25) drv_n = 1'b0;
            if (c == F + 25 + F + 5) drv_n = 1'b1;
            @(negedge clk);
            if (int_rst) hi++;
        end
        check("R10 count not restarted", hi, S);
        check("R10 kind short", rst_kind, 1);

        // R8: asynchronous pre-emption at several points
        async_at(4, "in filter");
        async_at(F + 12, "mid count");
        async_at(F + S + 20, "long wait");

        // R9: request ignored while pin high
        lo = 0;
        @(negedge clk);
        async_req = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (async_rst || int_rst || !ext_rst_n) lo++;
        end
        async_req = 1'b0;
        check("R9 request ignored with pin high", lo, 0);
        check("R12 kind held", rst_kind, 3);

        // R1: power-on reset mid-sequence
        @(negedge clk);
        drv_n = 1'b0;
        repeat (F + 10) @(negedge clk);
        check("R1 sequence running before por", int_rst, 1);
        por_n = 1'b0;
        drv_n = 1'b1;
        @(negedge clk);
        check("R1 por clears int_rst", int_rst, 0);
        check("R1 por clears kind", rst_kind, 0);
        check("R1 por releases ext", ext_rst_n, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule